// File: doc/BRIEF.md
# Supply Power-Good Monitor with Qualified Release

This block judges whether a regulated supply rail is healthy. Each clock it receives a digitised sample of the rail voltage and the active setpoint, both as unsigned millivolt codes. From the setpoint it derives two thresholds. The lower one sits at three quarters of the setpoint and the upper one at nine tenths. The block reports "good" only after the sample has stayed at or above the upper threshold for a programmable number of consecutive clocks. It returns to "not good" on the first clock at which the sample is below the lower threshold. The gap between the two thresholds is the hysteresis band. While the sample sits inside that band, the current verdict holds.

The verdict drives two registered outputs. `pwr_ok` is a plain status bit. `pull_n` is the request to an open-drain pad: 0 means pull the pin low (not good) and 1 means release it (good). When `enable` is low the monitor is in standby. It reports not good and discards any partial qualification. The thresholds are recomputed from `target_mv` on every cycle, so a change of setpoint takes effect at the next clock edge.

Top module: `pg_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pwr_ok` is 0 and `pull_n` is 0, whatever `enable` and `vout_mv` are.
- R2: The lower threshold is floor(`target_mv`×3/4) and the upper threshold is floor(`target_mv`×9/10), both in integer mV. For example, a target of 1001 gives 750 and 900.
- R3: With `enable` high and `pwr_ok` at 1, a clock edge at which `vout_mv` is below the lower threshold clears `pwr_ok` at that edge.
- R4: With `enable` high and `pwr_ok` at 1, a `vout_mv` at or above the lower threshold keeps `pwr_ok` at 1, including values inside the hysteresis band.
- R5: From not good, `pwr_ok` rises at the DELAY_CYCLES-th consecutive clock edge at which `enable` is high and `vout_mv` is at or above the upper threshold. Before that edge it stays 0.
- R6: During qualification, one edge at which `vout_mv` is below the upper threshold restarts the count. A further full DELAY_CYCLES qualifying edges are then needed.
- R7: An edge at which `enable` is low leaves `pwr_ok` at 0 after it and clears any partial qualification.
- R8: `pull_n` equals `pwr_ok` on every cycle, so the pad is pulled low exactly when the rail is not good.
- R9: A change of `target_mv` is used from the next edge. A rise that places `vout_mv` below the new lower threshold drops a good verdict at that edge, and a rise that keeps `vout_mv` at or above it does not.
- R10: While not good, a `vout_mv` held inside the hysteresis band never produces a good verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High to monitor; low for standby (not good) |
| vout_mv | input | DATA_W | Sampled rail voltage in mV |
| target_mv | input | DATA_W | Active setpoint in mV |
| pwr_ok | output | 1 | 1 when the rail is judged good |
| pull_n | output | 1 | Open-drain pad request: 0 pulls low, 1 releases |

## Verification
The checker assumes that `vout_mv`, `target_mv` and `enable` are stable around each rising edge. It also assumes `target_mv` is small enough that target×9 fits the product width, which holds for any millivolt setpoint in a 16-bit code. The bench changes every input only on the falling edge. It keeps setpoints near one volt, and it places samples exactly on and one millivolt beside each threshold, so the floor rounding of both fractions is exercised. Qualification runs use a short delay parameter. This keeps every full run, interrupted run and standby-aborted run within a few dozen clocks.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_STANDBY = 2'd0,
    PG_LOW     = 2'd1,
    PG_QUAL    = 2'd2,
    PG_GOOD    = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pg_thresh.sv
// Scales a millivolt setpoint by NUM/DEN with truncation.
module pg_thresh #(
  parameter int DATA_W = 16,
  parameter int NUM    = 3,
  parameter int DEN    = 4
) (
  input  logic [DATA_W-1:0] target_mv,
  output logic [DATA_W-1:0] thr_mv
);
  localparam int PROD_W = DATA_W + $clog2(NUM + 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  assign prod   = PROD_W'(target_mv) * PROD_W'(NUM);
  assign quot   = prod / PROD_W'(DEN);
  assign thr_mv = quot[DATA_W-1:0];
endmodule

// File: rtl/pg_qual_timer.sv
// Counts consecutive qualifying edges; done marks the last one.
module pg_qual_timer #(
  parameter int DELAY_CYCLES = 500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!run || done) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pg_monitor.sv
module pg_monitor #(
  parameter int DATA_W       = 16,
  parameter int DELAY_CYCLES = 500_000,
  parameter int LO_NUM       = 3,
  parameter int LO_DEN       = 4,
  parameter int HI_NUM       = 9,
  parameter int HI_DEN       = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DATA_W-1:0] vout_mv,
  input  logic [DATA_W-1:0] target_mv,
  output logic              pwr_ok,
  output logic              pull_n
);
  import pg_pkg::*;

  logic [DATA_W-1:0] thr_lo;
  logic [DATA_W-1:0] thr_hi;
  logic              below_lo;
  logic              at_hi;
  logic              qual_run;
  logic              qual_done;
  pg_state_e         state, state_nxt;

  pg_thresh #(.DATA_W(DATA_W), .NUM(LO_NUM), .DEN(LO_DEN)) u_thr_lo (
    .target_mv(target_mv),
    .thr_mv   (thr_lo)
  );

  pg_thresh #(.DATA_W(DATA_W), .NUM(HI_NUM), .DEN(HI_DEN)) u_thr_hi (
    .target_mv(target_mv),
    .thr_mv   (thr_hi)
  );

  assign below_lo = (vout_mv < thr_lo);
  assign at_hi    = (vout_mv >= thr_hi);
  assign qual_run = enable && (state != PG_GOOD) && at_hi;

  pg_qual_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (qual_run),
    .done(qual_done)
  );

  always_comb begin
    state_nxt = state;
    if (!enable) begin
      state_nxt = PG_STANDBY;
    end else if (state == PG_GOOD) begin
      state_nxt = below_lo ? PG_LOW : PG_GOOD;
    end else if (qual_done) begin
      state_nxt = PG_GOOD;
    end else if (at_hi) begin
      state_nxt = PG_QUAL;
    end else begin
      state_nxt = PG_LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PG_STANDBY;
      pwr_ok <= 1'b0;
      pull_n <= 1'b0;
    end else begin
      state  <= state_nxt;
      pwr_ok <= (state_nxt == PG_GOOD);
      pull_n <= (state_nxt == PG_GOOD);
    end
  end
endmodule

// File: rtl/pg_monitor_chk.sv
module pg_monitor_chk #(
  parameter int DATA_W       = 16,
  parameter int DELAY_CYCLES = 500_000,
  parameter int LO_NUM       = 3,
  parameter int LO_DEN       = 4,
  parameter int HI_NUM       = 9,
  parameter int HI_DEN       = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [DATA_W-1:0] vout_mv,
  input logic [DATA_W-1:0] target_mv,
  input logic              pwr_ok,
  input logic              pull_n
);
  logic [31:0] lo_ref, hi_ref, streak;

  assign lo_ref = (32'(target_mv) * 32'(LO_NUM)) / 32'(LO_DEN);
  assign hi_ref = (32'(target_mv) * 32'(HI_NUM)) / 32'(HI_DEN);

  always_ff @(posedge clk) begin
    if (rst) streak <= '0;
    else if (enable && (32'(vout_mv) >= hi_ref))
      streak <= (streak == 32'hFFFF_FFFF) ? streak : streak + 1;
    else streak <= '0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !pwr_ok);
  assert_pin_mirror_R8: assert property (@(posedge clk) disable iff (rst)
    pull_n == pwr_ok);
  assert_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && pwr_ok && (32'(vout_mv) < lo_ref)) |=> !pwr_ok);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && pwr_ok && (32'(vout_mv) >= lo_ref)) |=> pwr_ok);
  assert_standby_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pwr_ok);
  assert_qual_delay_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_ok) |-> (streak >= 32'(DELAY_CYCLES)));
  assert_rise_source_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_ok) |-> $past(enable && (32'(vout_mv) >= hi_ref)));
endmodule

bind pg_monitor pg_monitor_chk #(
  .DATA_W(DATA_W), .DELAY_CYCLES(DELAY_CYCLES),
  .LO_NUM(LO_NUM), .LO_DEN(LO_DEN), .HI_NUM(HI_NUM), .HI_DEN(HI_DEN)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .vout_mv(vout_mv),
  .target_mv(target_mv), .pwr_ok(pwr_ok), .pull_n(pull_n)
);

// File: tb/tb_pg_monitor.sv
`timescale 1ns/1ps
module tb_pg_monitor;
  localparam int DW = 16;
  localparam int D  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [DW-1:0] vout_mv = '0;
  logic [DW-1:0] target_mv = '0;
  logic          pwr_ok, pull_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  typedef struct { bit exp; string tag; } sb_item_t;
  sb_item_t sb[$];
  sb_item_t cur;

  always #5 clk = ~clk;

  pg_monitor #(.DATA_W(DW), .DELAY_CYCLES(D)) dut (
    .clk(clk), .rst(rst), .enable(enable), .vout_mv(vout_mv),
    .target_mv(target_mv), .pwr_ok(pwr_ok), .pull_n(pull_n)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: compare outputs after each edge against queued expectations.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      check(pwr_ok, cur.exp, cur.tag);
      check(pull_n, cur.exp, "R8 pull_n");
    end
  end

  // Driver: apply inputs at the falling edge, push expected result after next edge.
  task automatic step(input bit e, input int v, input int t, input bit exp,
                      input string tag);
    enable    = e;
    vout_mv   = DW'(v);
    target_mv = DW'(t);
    sb.push_back('{exp, tag});
    @(negedge clk);
  endtask

  task automatic qualify(input int v, input int t, input string tag);
    for (int i = 0; i < D; i++) step(1'b1, v, t, (i == D - 1), tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset holds not-good even with a healthy rail and enable high
    enable = 1'b1; vout_mv = 16'd950; target_mv = 16'd1000;
    repeat (D + 4) @(negedge clk);
    check(pwr_ok, 1'b0, "R1 in reset");
    check(pull_n, 1'b0, "R1 pull_n in reset");
    rst = 1'b0;
    step(1'b1, 800, 1000, 1'b0, "R1 first cycle");
    // R10: inside band while not good never qualifies
    for (int i = 0; i < D + 4; i++) step(1'b1, 800, 1000, 1'b0, "R10 band");
    // R5: exact upper threshold qualifies on the D-th edge
    qualify(900, 1000, "R5 rise");
    for (int i = 0; i < 3; i++) step(1'b1, 900, 1000, 1'b1, "R5 held");
    // R4: band and exact lower threshold keep good
    step(1'b1, 750, 1000, 1'b1, "R4 at lo");
    step(1'b1, 800, 1000, 1'b1, "R4 band");
    // R3: one mV below lower threshold drops at once
    step(1'b1, 749, 1000, 1'b0, "R3 drop");
    step(1'b1, 749, 1000, 1'b0, "R3 stay low");
    // R6: a dip below 900 during counting restarts it
    for (int i = 0; i < 5; i++) step(1'b1, 950, 1000, 1'b0, "R6 partial");
    step(1'b1, 899, 1000, 1'b0, "R6 dip");
    qualify(950, 1000, "R6 full recount");
    // R9: setpoint changes
    step(1'b1, 950, 1200, 1'b1, "R9 lo=900 keeps good");
    step(1'b1, 950, 1300, 1'b0, "R9 lo=975 drops");
    // R2: floor rounding with target 1001 (lo 750, hi 900)
    step(1'b1, 899, 1001, 1'b0, "R2 below hi");
    qualify(900, 1001, "R2 hi floor");
    step(1'b1, 750, 1001, 1'b1, "R2 lo floor holds");
    step(1'b1, 749, 1001, 1'b0, "R2 lo floor drops");
    // R7: standby
    qualify(950, 1000, "R7 setup");
    step(1'b0, 950, 1000, 1'b0, "R7 disable drops");
    for (int i = 0; i < 3; i++) step(1'b0, 950, 1000, 1'b0, "R7 standby");
    for (int i = 0; i < 4; i++) step(1'b1, 950, 1000, 1'b0, "R7 partial");
    step(1'b0, 950, 1000, 1'b0, "R7 abort");
    qualify(950, 1000, "R7 recount");
    step(1'b1, 950, 1000, 1'b1, "R5 final hold");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule